// File: doc/BRIEF.md
# Debounced Power Switch Event Detector

This block watches one active-low push-button line that controls system power. A debounce stage filters the raw line. It passes a new level only after the line has held that level, with no transitions, for a set number of timebase ticks. The block then turns each falling edge of the filtered level into one of two events. If the main supply is absent, the edge is a switch-on request. If the main supply is present, the edge is a switch-off request. A separate long-press detector raises a power-down request when the filtered line stays low long enough, whatever the supply state.

Switch-on detection is blanked for a window after the main supply goes away, so that a press made while the supply is collapsing does not restart the system. Each detected on or off event sets its own sticky status bit. Software can poll these bits and clear them with one-cycle strobes.

Two state machines do the work. The debounce machine has the states `DB_STABLE` and `DB_SETTLE`. Its transitions are: start-settle, on a synchronized level that differs from the filtered one; bounce-back, on a return to the filtered level; and commit, after the last tick. The press machine has the states `SW_RELEASED`, `SW_HELD` and `SW_LONG`. Its transitions are: press, on a filtered fall; long-expire, on the last long-press tick; and release, on a filtered rise from either held state.

Top module: `pwr_switch_detect`

## Requirements
- R1: The raw line passes through two synchronizing flops. The filtered level takes a new value only after the synchronized line has differed from it for DEB_TICKS ticks in a row (one tick is TICK_DIV clocks). A return to the old level restarts the wait, so pulses shorter than that wait cause no event.
- R2: A filtered falling edge while `supply_ok` is 0 and no blanking window is active produces a one-cycle `on_evt` pulse.
- R3: A filtered falling edge while `supply_ok` is 1 produces a one-cycle `off_evt` pulse.
- R4: A 1-to-0 change of `supply_ok` opens a blanking window of MASK_TICKS ticks. A filtered falling edge inside the window produces no `on_evt` and does not set `on_seen`. A press after the window closes is detected normally.
- R5: `on_seen` goes to 1 in the same cycle as `on_evt`. It returns to 0 one cycle after a `clr_on` strobe.
- R6: `off_seen` goes to 1 in the same cycle as `off_evt`. It returns to 0 one cycle after a `clr_off` strobe.
- R7: When an event and the matching clear strobe fall on the same cycle, the status bit is set.
- R8: If the filtered level stays low for LONG_TICKS ticks after a falling edge, `long_evt` pulses for one cycle. This happens whatever `supply_ok` is, and only once per press.
- R9: After reset, the filtered level is released (high), both status bits are 0, no blanking window is active and no pulse is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_raw_n | input | 1 | Raw push-button line, low when pressed |
| supply_ok | input | 1 | Main supply present flag, synchronous to clk |
| clr_on | input | 1 | One-cycle strobe clearing on_seen |
| clr_off | input | 1 | One-cycle strobe clearing off_seen |
| on_evt | output | 1 | One-cycle switch-on event pulse |
| off_evt | output | 1 | One-cycle switch-off event pulse |
| long_evt | output | 1 | One-cycle long-press power-down pulse |
| on_seen | output | 1 | Sticky switch-on detected bit |
| off_seen | output | 1 | Sticky switch-off detected bit |

## Verification
A press changes the raw line; `on_evt` or `off_evt` follows 2 synchronizer cycles, 1 settle-entry cycle, DEB_TICKS ticks and 1 output register later. Because the tick phase is free-running, that delay is a window of one tick period, about 17 to 20 cycles with the bench parameters. `long_evt` follows LONG_TICKS ticks after the edge pulse. The status bits change in the same cycle as their pulse, and a clear takes effect one cycle after its strobe. The driver therefore pushes each expected pulse into a queue with its earliest and latest due cycle. The monitor, sampling on the falling clock edge, matches every pulse against the head of the queue and flags any unexpected pulse, so blanked and glitch cases are checked by absence.

// File: rtl/pwr_switch_pkg.sv
package pwr_switch_pkg;

    typedef enum logic {
        DB_STABLE = 1'b0,
        DB_SETTLE = 1'b1
    } db_state_e;

    typedef enum logic [1:0] {
        SW_RELEASED = 2'd0,
        SW_HELD     = 2'd1,
        SW_LONG     = 2'd2
    } sw_state_e;

endpackage

// File: rtl/pwr_switch_sync.sv
module pwr_switch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_switch_tick.sv
module pwr_switch_tick #(
    parameter int TICK_DIV = 33
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int TW = $clog2(TICK_DIV);
            localparam logic [TW-1:0] TLAST = TW'(TICK_DIV - 1);
            logic [TW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              cnt_q <= '0;
                else if (cnt_q == TLAST) cnt_q <= '0;
                else                     cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == TLAST);
        end
    endgenerate
endmodule

// File: rtl/pwr_switch_debounce.sv
module pwr_switch_debounce
    import pwr_switch_pkg::*;
#(
    parameter int DEB_TICKS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sync_lvl,
    output logic db_lvl
);
    localparam int DW = $clog2(DEB_TICKS + 1);
    localparam logic [DW-1:0] DLAST = DW'(DEB_TICKS - 1);

    db_state_e state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic          lvl_q;
    logic          commit;

    assign commit = (state_q == DB_SETTLE) && (sync_lvl != lvl_q) && tick && (cnt_q == DLAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DB_STABLE: if (sync_lvl != lvl_q) state_d = DB_SETTLE;      // start-settle
            DB_SETTLE: begin
                if (sync_lvl == lvl_q) state_d = DB_STABLE;             // bounce-back
                else if (commit)       state_d = DB_STABLE;             // commit
            end
            default:                   state_d = DB_STABLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DB_STABLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else begin
            if (state_q != DB_SETTLE || sync_lvl == lvl_q) cnt_q <= '0;
            else if (tick)                                  cnt_q <= cnt_q + 1'b1;
            if (commit) lvl_q <= sync_lvl;
        end
    end

    assign db_lvl = lvl_q;

    assert_db_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(sync_lvl)));
    assert_db_needs_settle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> ($past(state_q) == DB_SETTLE));
endmodule

// File: rtl/pwr_switch_mask.sv
module pwr_switch_mask #(
    parameter int MASK_TICKS = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    output logic mask_active
);
    localparam int MW = $clog2(MASK_TICKS + 1);
    localparam logic [MW-1:0] MLOAD = MW'(MASK_TICKS);

    logic          supply_q;
    logic [MW-1:0] left_q;
    logic          supply_fall;

    assign supply_fall = supply_q && !supply_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            supply_q <= 1'b0;
            left_q   <= '0;
        end else begin
            supply_q <= supply_ok;
            if (supply_fall)                  left_q <= MLOAD;
            else if (tick && left_q != '0)    left_q <= left_q - 1'b1;
        end
    end

    assign mask_active = (left_q != '0);

    assert_mask_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(supply_q) && !$past(supply_ok)) |-> mask_active);
endmodule

// File: rtl/pwr_switch_detect.sv
module pwr_switch_detect
    import pwr_switch_pkg::*;
#(
    parameter int TICK_DIV   = 33,
    parameter int DEB_TICKS  = 15,
    parameter int MASK_TICKS = 1500,
    parameter int LONG_TICKS = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_raw_n,
    input  logic supply_ok,
    input  logic clr_on,
    input  logic clr_off,
    output logic on_evt,
    output logic off_evt,
    output logic long_evt,
    output logic on_seen,
    output logic off_seen
);
    localparam int LW = $clog2(LONG_TICKS + 1);
    localparam logic [LW-1:0] LLAST = LW'(LONG_TICKS - 1);

    logic tick, sync_lvl, db_lvl, mask_active;

    pwr_switch_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    pwr_switch_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(sw_raw_n), .d_out(sync_lvl));

    pwr_switch_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sync_lvl(sync_lvl), .db_lvl(db_lvl));

    pwr_switch_mask #(.MASK_TICKS(MASK_TICKS)) u_mask (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .mask_active(mask_active));

    sw_state_e     state_q, state_d;
    logic [LW-1:0] hold_q;
    logic          press, long_hit, on_set, off_set;

    assign press    = (state_q == SW_RELEASED) && !db_lvl;
    assign long_hit = (state_q == SW_HELD) && !db_lvl && tick && (hold_q == LLAST);
    assign on_set   = press && !supply_ok && !mask_active;
    assign off_set  = press && supply_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_RELEASED: if (!db_lvl) state_d = SW_HELD;              // press
            SW_HELD: begin
                if (db_lvl)        state_d = SW_RELEASED;             // release
                else if (long_hit) state_d = SW_LONG;                 // long-expire
            end
            SW_LONG:     if (db_lvl) state_d = SW_RELEASED;           // release
            default:                 state_d = SW_RELEASED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_RELEASED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            on_evt   <= 1'b0;
            off_evt  <= 1'b0;
            long_evt <= 1'b0;
            on_seen  <= 1'b0;
            off_seen <= 1'b0;
        end else begin
            if (state_q != SW_HELD) hold_q <= '0;
            else if (tick)          hold_q <= hold_q + 1'b1;
            on_evt   <= on_set;
            off_evt  <= off_set;
            long_evt <= long_hit;
            if (on_set)       on_seen <= 1'b1;
            else if (clr_on)  on_seen <= 1'b0;
            if (off_set)      off_seen <= 1'b1;
            else if (clr_off) off_seen <= 1'b0;
        end
    end

    assert_on_off_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(on_evt && off_evt));
    assert_on_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        on_evt |=> !on_evt);
    assert_off_needs_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        off_evt |-> $past(supply_ok));
    assert_on_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        on_evt |-> (!$past(mask_active) && !$past(supply_ok)));
    assert_on_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        on_evt |-> on_seen);
    assert_off_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        off_evt |-> off_seen);
    assert_long_when_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        long_evt |-> !$past(db_lvl));
    assert_long_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        long_evt |=> !long_evt);
endmodule

// File: tb/tb_pwr_switch_detect.sv
module tb_pwr_switch_detect;
    localparam int TD = 4, DEB = 4, MASK = 30, LONG = 25;

    typedef struct { int kind; int lo; int hi; } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sw_raw_n = 1'b1, supply_ok = 1'b0, clr_on = 1'b0, clr_off = 1'b0;
    logic on_evt, off_evt, long_evt, on_seen, off_seen;

    int cyc = 0, checks = 0, fails = 0;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_switch_detect #(.TICK_DIV(TD), .DEB_TICKS(DEB), .MASK_TICKS(MASK), .LONG_TICKS(LONG)) dut (
        .clk(clk), .rst_n(rst_n), .sw_raw_n(sw_raw_n), .supply_ok(supply_ok),
        .clr_on(clr_on), .clr_off(clr_off), .on_evt(on_evt), .off_evt(off_evt),
        .long_evt(long_evt), .on_seen(on_seen), .off_seen(off_seen));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pop and compare every pulse against the scoreboard head
    task automatic match(input int kind, input string req);
        exp_t e;
        if (sb.size() == 0) begin
            check(1'b0, {req, " unexpected pulse"}, kind, -1);
        end else begin
            e = sb.pop_front();
            check(e.kind == kind, {req, " pulse kind"}, kind, e.kind);
            check(cyc >= e.lo && cyc <= e.hi, {req, " pulse timing"}, cyc, e.lo);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        if (on_evt) begin
            match(0, "R2");
            check(on_seen == 1'b1, "R5/R7 on_seen with pulse", int'(on_seen), 1);
        end
        if (off_evt) begin
            match(1, "R3");
            check(off_seen == 1'b1, "R6 off_seen with pulse", int'(off_seen), 1);
        end
        if (long_evt) match(2, "R8");
    end

    // Driver: press for hold cycles, pushing the expected pulses
    task automatic press(input int hold, input int edge_kind, input bit exp_long);
        int c;
        @(negedge clk);
        sw_raw_n = 1'b0;
        c = cyc;
        if (edge_kind >= 0) sb.push_back('{edge_kind, c + 15, c + 22});
        if (exp_long) sb.push_back('{2, c + 15 + (LONG - 1) * TD, c + 22 + LONG * TD + 2});
        repeat (hold) @(negedge clk);
        sw_raw_n = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic glitch(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sw_raw_n = 1'b0;
            repeat (3) @(negedge clk); sw_raw_n = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic pulse_clr(input bit which_on);
        @(negedge clk);
        if (which_on) clr_on = 1'b1; else clr_off = 1'b1;
        @(negedge clk);
        clr_on = 1'b0; clr_off = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(!on_evt && !off_evt && !long_evt, "R9 no pulses", int'(on_evt | off_evt | long_evt), 0);
        check(!on_seen && !off_seen, "R9 status clear", int'({on_seen, off_seen}), 0);
        repeat (40) @(negedge clk);
        check(sb.size() == 0 && !on_seen, "R9 released level gives no event", int'(on_seen), 0);

        // R2, R5: switch-on with supply absent, then clear
        press(40, 0, 1'b0);
        check(on_seen == 1'b1, "R5 on_seen set", int'(on_seen), 1);
        check(off_seen == 1'b0, "R2 off_seen untouched", int'(off_seen), 0);
        pulse_clr(1'b1);
        check(on_seen == 1'b0, "R5 on_seen cleared", int'(on_seen), 0);

        // R8: long press with supply absent
        press(LONG * TD + 40, 0, 1'b1);
        pulse_clr(1'b1);

        // R7: clear held high while an on event lands
        @(negedge clk); clr_on = 1'b1;
        press(40, 0, 1'b0);
        clr_on = 1'b0;
        @(negedge clk);
        check(on_seen == 1'b0, "R7 clear after set", int'(on_seen), 0);

        // R3, R6: switch-off with supply present
        supply_ok = 1'b1;
        repeat (5) @(negedge clk);
        press(40, 1, 1'b0);
        check(off_seen == 1'b1, "R6 off_seen set", int'(off_seen), 1);
        check(on_seen == 1'b0, "R3 on_seen untouched", int'(on_seen), 0);
        pulse_clr(1'b0);
        check(off_seen == 1'b0, "R6 off_seen cleared", int'(off_seen), 0);

        // R1: short glitches produce nothing
        glitch(4);
        repeat (40) @(negedge clk);
        check(off_seen == 1'b0, "R1 glitches ignored", int'(off_seen), 0);
        // R1: bouncy press yields exactly one event
        glitch(3);
        press(40, 1, 1'b0);
        pulse_clr(1'b0);

        // R8: long press with supply present
        press(LONG * TD + 60, 1, 1'b1);
        pulse_clr(1'b0);

        // R4: press inside the blanking window
        @(negedge clk); supply_ok = 1'b0;
        repeat (4) @(negedge clk);
        press(40, -1, 1'b0);
        check(on_seen == 1'b0, "R4 masked press sets nothing", int'(on_seen), 0);
        repeat (MASK * TD) @(negedge clk);
        press(40, 0, 1'b0);
        check(on_seen == 1'b1, "R4 press after window detected", int'(on_seen), 1);

        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule